// File: doc/BRIEF.md
# ACPI Event Status Aggregator

This block keeps a small bank of general-purpose event bytes, the status half and the enable half, and merges them with the fixed power-management event vectors into a single level-sensitive system control interrupt. Hotplug logic elsewhere in the chip pulses one of two event strobes. Each strobe latches a sticky status bit. Firmware reads those bits through a byte-lane register port, masks them through the enable bytes, and acknowledges them by writing ones back.

The register port takes accesses of one to four bytes. Each access is split into bytes in little-endian order: lane k of the data word addresses byte `addr + k`. Lanes that land past the end of the bank are dropped. The port has no valid/ready pair. A write or read strobe is accepted in the same cycle it is raised, the port never applies back-pressure, and read data shows up on `rdata` one cycle later and stays there until the next read.

The block also raises a timer-arm request when the fixed timer event is enabled and its status is still clear. The timer itself, sleep control and the SMI path live elsewhere.

Top module: `gpe_sci_hub`

## Requirements
- R1: After reset, every status and enable byte reads as zero and `sci` is low.
- R2: Byte 0 and byte 1 are status bytes. Writing a 1 to a status bit clears it, and writing a 0 leaves it unchanged.
- R3: Byte 2 and byte 3 are enable bytes and hold the written value. They change only when a write reaches them.
- R4: A write with `size` = n (n = 0..3) carries n+1 bytes. Lane k (`wdata[8k+7:8k]`) goes to byte `addr+k`, and lanes whose byte index is 4 or more are discarded.
- R5: A read loads `rdata` on the next clock. Lane k holds byte `addr+k` for k <= `size`, and it reads as zero when k > `size` or when `addr+k` is 4 or more.
- R6: A pulse on `pci_evt` sets bit 1 of status byte 0, and a pulse on `cpu_evt` sets bit 2. No other status bit can ever become 1.
- R7: An event strobe in the same cycle as a write that clears the same bit leaves the bit set.
- R8: `sci` is high whenever `fix_sts & fix_en` has any of bits 0 (timer), 5 (global lock), 8 (power button) or 10 (real-time clock) set. No other fixed bit contributes.
- R9: `sci` is also high whenever status byte 0 AND enable byte 0 has bit 1 or bit 2 set. It follows a write or event from the clock edge that stores it.
- R10: `tmr_arm` is high exactly when `fix_en[0]` is 1 and `fix_sts[0]` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Starting byte index in the bank |
| size | input | 2 | Access length minus one, in bytes |
| wdata | input | 32 | Write data, lane 0 in the low byte |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| pci_evt | input | 1 | PCI hotplug event pulse |
| cpu_evt | input | 1 | CPU hotplug event pulse |
| fix_sts | input | 16 | Fixed event status vector |
| fix_en | input | 16 | Fixed event enable vector |
| sci | output | 1 | Level interrupt request |
| tmr_arm | output | 1 | Request to arm the periodic timer |

## Verification
The assertions assume that `fix_sts` and `fix_en` are steady, clean levels and that the strobes are sampled only on rising clock edges. They make no assumption about how `rd_en`, `wr_en` and the event strobes overlap. The bench changes every input on the falling edge and holds it for a full cycle, so all values seen at a rising edge are settled. It deliberately fires an event in the same cycle as a clearing write so that the priority rule is exercised.

// File: rtl/gpe_pkg.sv
package gpe_pkg;
  typedef logic [7:0] byte_t;
  localparam int PCI_HP_BIT   = 1;
  localparam int CPU_HP_BIT   = 2;
  localparam int FIX_TMR_BIT  = 0;
  localparam logic [15:0] FIX_SCI_MASK = 16'h0521;
  localparam byte_t GPE_SCI_MASK = 8'h06;
endpackage

// File: rtl/gpe_lane_sel.sv
module gpe_lane_sel #(
  parameter int BYTE_IDX  = 0,
  parameter int BUS_BYTES = 4,
  parameter int AW        = 2,
  parameter int SZW       = 2
) (
  input  logic                   req,
  input  logic [AW-1:0]          addr,
  input  logic [SZW-1:0]         size,
  input  logic [8*BUS_BYTES-1:0] wdata,
  output logic                   hit,
  output gpe_pkg::byte_t         data
);
  int              off;
  logic [SZW-1:0]  lane;

  always_comb begin
    off  = BYTE_IDX - int'(addr);
    lane = off[SZW-1:0];
    hit  = req && (off >= 0) && (off <= int'(size)) && (off < BUS_BYTES);
    data = hit ? wdata[8*lane +: 8] : '0;
  end
endmodule

// File: rtl/gpe_bank.sv
module gpe_bank #(
  parameter int NBYTES    = 4,
  parameter int BUS_BYTES = 4,
  parameter int AW        = 2,
  parameter int SZW       = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [AW-1:0]          addr,
  input  logic [SZW-1:0]         size,
  input  logic [8*BUS_BYTES-1:0] wdata,
  input  logic                   pci_evt,
  input  logic                   cpu_evt,
  output logic [8*NBYTES-1:0]    bytes_o
);
  import gpe_pkg::*;
  localparam int NSTS = NBYTES / 2;

  byte_t regs_q [NBYTES];

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    logic  hit;
    byte_t wbyte;
    byte_t setv;

    gpe_lane_sel #(
      .BYTE_IDX(b), .BUS_BYTES(BUS_BYTES), .AW(AW), .SZW(SZW)
    ) i_sel (
      .req(wr_en), .addr(addr), .size(size), .wdata(wdata),
      .hit(hit), .data(wbyte)
    );

    if (b == 0) begin : g_evt
      always_comb begin
        setv = '0;
        setv[PCI_HP_BIT] = pci_evt;
        setv[CPU_HP_BIT] = cpu_evt;
      end
    end else begin : g_noevt
      assign setv = '0;
    end

    if (b < NSTS) begin : g_sts
      always_ff @(posedge clk) begin
        if (!rst_n) regs_q[b] <= '0;
        else        regs_q[b] <= (regs_q[b] & ~wbyte) | setv;
      end
    end else begin : g_en
      always_ff @(posedge clk) begin
        if (!rst_n)   regs_q[b] <= '0;
        else if (hit) regs_q[b] <= wbyte;
      end
    end

    assign bytes_o[8*b +: 8] = regs_q[b];
  end
endmodule

// File: rtl/gpe_sci_logic.sv
module gpe_sci_logic #(
  parameter int          FIX_W   = 16,
  parameter logic [15:0] FIX_MSK = gpe_pkg::FIX_SCI_MASK,
  parameter logic [7:0]  GPE_MSK = gpe_pkg::GPE_SCI_MASK,
  parameter int          TMR_BIT = gpe_pkg::FIX_TMR_BIT
) (
  input  logic [FIX_W-1:0] fix_sts,
  input  logic [FIX_W-1:0] fix_en,
  input  gpe_pkg::byte_t   gpe_sts0,
  input  gpe_pkg::byte_t   gpe_en0,
  output logic             sci,
  output logic             tmr_arm
);
  logic fix_hit;
  logic gpe_hit;

  always_comb begin
    fix_hit = |(fix_sts & fix_en & FIX_MSK[FIX_W-1:0]);
    gpe_hit = |(gpe_sts0 & gpe_en0 & GPE_MSK);
    sci     = fix_hit | gpe_hit;
    tmr_arm = fix_en[TMR_BIT] & ~fix_sts[TMR_BIT];
  end
endmodule

// File: rtl/gpe_sci_hub.sv
module gpe_sci_hub #(
  parameter int NBYTES    = 4,
  parameter int BUS_BYTES = 4,
  parameter int FIX_W     = 16
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic                             rd_en,
  input  logic [$clog2(NBYTES)-1:0]        addr,
  input  logic [$clog2(BUS_BYTES)-1:0]     size,
  input  logic [8*BUS_BYTES-1:0]           wdata,
  output logic [8*BUS_BYTES-1:0]           rdata,
  input  logic                             pci_evt,
  input  logic                             cpu_evt,
  input  logic [FIX_W-1:0]                 fix_sts,
  input  logic [FIX_W-1:0]                 fix_en,
  output logic                             sci,
  output logic                             tmr_arm
);
  localparam int AW   = $clog2(NBYTES);
  localparam int SZW  = $clog2(BUS_BYTES);
  localparam int NSTS = NBYTES / 2;

  logic [8*NBYTES-1:0]    bank_bytes;
  logic [8*BUS_BYTES-1:0] rd_next;
  logic [8*BUS_BYTES-1:0] rdata_q;

  gpe_bank #(
    .NBYTES(NBYTES), .BUS_BYTES(BUS_BYTES), .AW(AW), .SZW(SZW)
  ) i_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .size(size),
    .wdata(wdata), .pci_evt(pci_evt), .cpu_evt(cpu_evt),
    .bytes_o(bank_bytes)
  );

  gpe_sci_logic #(.FIX_W(FIX_W)) i_sci (
    .fix_sts(fix_sts), .fix_en(fix_en),
    .gpe_sts0(bank_bytes[7:0]),
    .gpe_en0(bank_bytes[8*NSTS +: 8]),
    .sci(sci), .tmr_arm(tmr_arm)
  );

  for (genvar k = 0; k < BUS_BYTES; k++) begin : g_rlane
    int idx;
    always_comb begin
      idx = int'(addr) + k;
      if (k <= int'(size) && idx < NBYTES)
        rd_next[8*k +: 8] = bank_bytes[8*idx[AW-1:0] +: 8];
      else
        rd_next[8*k +: 8] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_next;
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/gpe_sci_hub_chk.sv
module gpe_sci_hub_chk #(
  parameter int NBYTES = 4,
  parameter int FIX_W  = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic                pci_evt,
  input logic                cpu_evt,
  input logic [FIX_W-1:0]    fix_sts,
  input logic [FIX_W-1:0]    fix_en,
  input logic                sci,
  input logic                tmr_arm,
  input logic [8*NBYTES-1:0] bank_bytes
);
  localparam int HALF = 4 * NBYTES;
  logic [HALF-1:0] sts_v;
  logic [HALF-1:0] en_v;
  logic [HALF-1:0] legal_sts;
  assign sts_v = bank_bytes[HALF-1:0];
  assign en_v  = bank_bytes[8*NBYTES-1:HALF];
  assign legal_sts = HALF'(gpe_pkg::GPE_SCI_MASK);

  // R6
  sts_bits_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_v & ~legal_sts) == '0);
  // R7
  pci_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pci_evt |=> sts_v[gpe_pkg::PCI_HP_BIT]);
  // R7
  cpu_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_evt |=> sts_v[gpe_pkg::CPU_HP_BIT]);
  // R3
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(en_v));
  // R2
  sts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !pci_evt && !cpu_evt) |=> $stable(sts_v));
  // R8
  fix_sci_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(fix_sts & fix_en & gpe_pkg::FIX_SCI_MASK[FIX_W-1:0])) |-> sci);
  // R10
  tmr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fix_sts[gpe_pkg::FIX_TMR_BIT] |-> !tmr_arm);
endmodule

bind gpe_sci_hub gpe_sci_hub_chk #(.NBYTES(NBYTES), .FIX_W(FIX_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .pci_evt(pci_evt),
  .cpu_evt(cpu_evt), .fix_sts(fix_sts), .fix_en(fix_en), .sci(sci),
  .tmr_arm(tmr_arm), .bank_bytes(bank_bytes)
);

// File: tb/test_gpe_sci_hub.sv
module test_gpe_sci_hub;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  addr = '0, size = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        pci_evt = 1'b0, cpu_evt = 1'b0;
  logic [15:0] fix_sts = '0, fix_en = '0;
  logic        sci, tmr_arm;
  int          n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  gpe_sci_hub i_gpe_sci_hub (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .size(size), .wdata(wdata), .rdata(rdata), .pci_evt(pci_evt),
    .cpu_evt(cpu_evt), .fix_sts(fix_sts), .fix_en(fix_en), .sci(sci),
    .tmr_arm(tmr_arm)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [1:0] s, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; size = s; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, logic [1:0] s, logic [31:0] exp, string req);
    @(negedge clk);
    rd_en = 1'b1; addr = a; size = s;
    @(negedge clk);
    rd_en = 1'b0;
    check(req, rdata, exp);
  endtask

  task automatic pulse(logic p, logic c);
    @(negedge clk);
    pci_evt = p; cpu_evt = c;
    @(negedge clk);
    pci_evt = 1'b0; cpu_evt = 1'b0;
  endtask

  task automatic t_reset;
    rd(2'd0, 2'd3, 32'h0, "R1 bank after reset");
    check("R1 sci after reset", 32'(sci), 32'h0);
  endtask

  task automatic t_lanes;
    wr(2'd0, 2'd3, 32'hAABBCCDD);                 // R4: lanes 2,3 reach enables
    rd(2'd2, 2'd1, 32'h0000AABB, "R4 full-width write");
    rd(2'd0, 2'd1, 32'h0, "R2 zero status ignores write");
    wr(2'd3, 2'd3, 32'h11223344);                 // R4: only lane 0 lands
    rd(2'd2, 2'd1, 32'h000044BB, "R4 overflow lanes dropped");
    rd(2'd2, 2'd0, 32'h000000BB, "R5 single byte read");
    rd(2'd3, 2'd3, 32'h00000044, "R5 past-end lanes zero");
    wr(2'd2, 2'd0, 32'hFFFFFF5A);                 // R3: only byte 2 written
    rd(2'd2, 2'd1, 32'h0000445A, "R3 enable byte plain write");
  endtask

  task automatic t_events;
    wr(2'd2, 2'd0, 32'h0);
    pulse(1'b1, 1'b0);
    rd(2'd0, 2'd0, 32'h02, "R6 pci event sets bit 1");
    check("R9 masked gpe no sci", 32'(sci), 32'h0);
    pulse(1'b0, 1'b1);
    rd(2'd0, 2'd0, 32'h06, "R6 cpu event sets bit 2");
    wr(2'd2, 2'd0, 32'h04);
    check("R9 cpu bit enabled raises sci", 32'(sci), 32'h1);
    wr(2'd0, 2'd0, 32'h02);
    rd(2'd0, 2'd0, 32'h04, "R2 write-one clears only bit 1");
    wr(2'd0, 2'd0, 32'h04);
    check("R9 sci drops after clear", 32'(sci), 32'h0);
    rd(2'd0, 2'd1, 32'h0, "R2 status cleared");
  endtask

  task automatic t_priority;
    @(negedge clk);
    wr_en = 1'b1; addr = 2'd0; size = 2'd0; wdata = 32'h02; pci_evt = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; pci_evt = 1'b0;
    rd(2'd0, 2'd0, 32'h02, "R7 set wins over clear");
    wr(2'd2, 2'd0, 32'hF9);
    check("R9 non-event enables no sci", 32'(sci), 32'h0);
    wr(2'd2, 2'd0, 32'h02);
    check("R9 pci bit enabled raises sci", 32'(sci), 32'h1);
    wr(2'd0, 2'd0, 32'h02);
    wr(2'd2, 2'd0, 32'h00);
  endtask

  task automatic t_fixed;
    @(negedge clk); fix_sts = 16'h0020; fix_en = 16'h0020;
    #1 check("R8 global lock raises sci", 32'(sci), 32'h1);
    @(negedge clk); fix_sts = 16'h0002; fix_en = 16'h0002;
    #1 check("R8 unlisted bit no sci", 32'(sci), 32'h0);
    @(negedge clk); fix_sts = 16'h0500; fix_en = 16'h0400;
    #1 check("R8 rtc raises sci", 32'(sci), 32'h1);
    @(negedge clk); fix_sts = 16'h0100; fix_en = 16'h0400;
    #1 check("R8 enable mismatch no sci", 32'(sci), 32'h0);
    @(negedge clk); fix_sts = 16'h0000; fix_en = 16'h0001;
    #1 check("R10 timer armed", 32'(tmr_arm), 32'h1);
    check("R8 timer en without status", 32'(sci), 32'h0);
    @(negedge clk); fix_sts = 16'h0001;
    #1 check("R10 timer status blocks arm", 32'(tmr_arm), 32'h0);
    check("R8 timer event raises sci", 32'(sci), 32'h1);
    @(negedge clk); fix_sts = 16'h0000; fix_en = 16'h0000;
    #1 check("R10 timer disabled", 32'(tmr_arm), 32'h0);
  endtask

  initial begin
    #(20 * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_lanes();
    t_events();
    t_priority();
    t_fixed();
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule